// File: doc/BRIEF.md
# Receive Frequency Range Monitor

This block decides whether a clock-recovery loop may follow the incoming data stream. It measures the recovered character clock against a local reference clock and checks that the two agree to within a small parts-per-million tolerance. While the recovered rate is in tolerance, the block points the recovery loop at the data transitions. As soon as the rate drifts outside the tolerance, it points the loop back at the local reference, so the loop never follows a signal that is out of specification.

The measurement works in windows of `2^WIN_BITS` reference cycles. The recovered clock drives a free-running counter that is passed to the reference domain in Gray code. At each window end, the number of recovered cycles in the window is compared with the expected count. The reference can run at character rate or at half character rate, so the expected count is either one or two recovered cycles for each reference cycle. The in-range flag is meant to feed a link fault indicator. The lock select is meant to drive the phase detector's input mux.

Top module: `rx_freq_monitor`

## Requirements
- R1: While reset is asserted and after it is released, `inRange` is 0 and `lockData` is 0 until a verdict says otherwise.
- R2: With `halfRate` = 0, the expected count per window is `2^WIN_BITS` recovered cycles. A window whose count lies within that value plus or minus the tolerance is in range.
- R3: With `halfRate` = 1, the expected count per window is `2 * 2^WIN_BITS` recovered cycles. A recovered clock at the plain character rate is then out of range, and the reverse mismatch is out of range too.
- R4: The tolerance is ceil(expected * TOL_PPM / 1e6), with TOL_PPM = 200 by default. A count beyond the tolerance on either side, fast or slow, is out of range.
- R5: `lockData` rises only after two consecutive in-range windows. `lockData` = 1 implies `inRange` = 1.
- R6: A single out-of-range window clears both `inRange` and `lockData` at once.
- R7: `inRange` and `lockData` change only at a window verdict, which comes at most once per window.
- R8: The first window after reset only primes the measurement. The first verdict arrives at the end of the second window, about `2 * 2^WIN_BITS` reference cycles after reset.
- R9: A stopped recovered clock gives an out-of-range verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Local reference clock; defines the measurement windows |
| recClk | input | 1 | Recovered character clock under test |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| halfRate | input | 1 | 1: reference runs at half character rate (expected ratio 2:1); 0: character rate (1:1) |
| inRange | output | 1 | Last completed window was within tolerance |
| lockData | output | 1 | 1: recovery loop tracks data; 0: recovery loop aligns to reference |

## Verification
The bench uses a widened tolerance so that windows stay short. It drives recovered clocks just inside and just outside that tolerance, on both sides, in both rate modes. A design with the tolerance miscomputed, or with the expected count not doubled for half rate, gets these edge vectors wrong. The bench times the first verdict and the lock rise from reset. A design that skipped the priming window or locked after a single good window would move too early. It also stops the recovered clock and steps a locked link out of tolerance. A design that held the lock, or dropped only the flag, would be caught there.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
  // Verdict strobes from the measurement datapath to the lock control.
  typedef struct packed {
    logic verdict;  // one-cycle pulse: a window result is available
    logic pass;     // result of that window (valid with verdict)
  } rfm_strobe_t;
endpackage

// File: rtl/rfm_datapath.sv
module rfm_datapath
  import rfm_pkg::*;
#(
  parameter int WIN_BITS    = 16,
  parameter int TOL_PPM     = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic        refClk,
  input  logic        recClk,
  input  logic        rstN,
  input  logic        halfRate,
  output rfm_strobe_t stb
);
  localparam int    CNT_W    = WIN_BITS + 3;
  localparam longint EXP_ONE = longint'(1) << WIN_BITS;
  localparam longint EXP_TWO = EXP_ONE * 2;
  localparam longint TOL_ONE = (EXP_ONE * TOL_PPM + 999999) / 1000000;
  localparam longint TOL_TWO = (EXP_TWO * TOL_PPM + 999999) / 1000000;
  localparam logic [CNT_W-1:0] LO_ONE = CNT_W'(EXP_ONE - TOL_ONE);
  localparam logic [CNT_W-1:0] HI_ONE = CNT_W'(EXP_ONE + TOL_ONE);
  localparam logic [CNT_W-1:0] LO_TWO = CNT_W'(EXP_TWO - TOL_TWO);
  localparam logic [CNT_W-1:0] HI_TWO = CNT_W'(EXP_TWO + TOL_TWO);

  // Recovered-clock domain: binary counter published as Gray code.
  logic [CNT_W-1:0] recBin, recBinNext, recGray;
  assign recBinNext = recBin + 1'b1;

  always_ff @(posedge recClk or negedge rstN) begin
    if (!rstN) begin
      recBin  <= '0;
      recGray <= '0;
    end else begin
      recBin  <= recBinNext;
      recGray <= recBinNext ^ (recBinNext >> 1);
    end
  end

  // Reference domain: synchronizer chain, one stage per generate step.
  logic [CNT_W-1:0] syncQ [SYNC_STAGES];
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge refClk or negedge rstN) begin
        if (!rstN) syncQ[gi] <= '0;
        else if (gi == 0) syncQ[gi] <= recGray;
        else syncQ[gi] <= syncQ[(gi == 0) ? 0 : gi - 1];
      end
    end
  endgenerate

  function automatic logic [CNT_W-1:0] grayToBin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [CNT_W-1:0] curBin, lastBin, delta, lo, hi;
  logic [WIN_BITS-1:0] winCnt;
  logic windowEnd, primed, deltaOk;

  assign curBin    = grayToBin(syncQ[SYNC_STAGES-1]);
  assign delta     = curBin - lastBin;
  assign windowEnd = &winCnt;
  assign lo        = halfRate ? LO_TWO : LO_ONE;
  assign hi        = halfRate ? HI_TWO : HI_ONE;
  assign deltaOk   = (delta >= lo) && (delta <= hi);

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      winCnt  <= '0;
      lastBin <= '0;
      primed  <= 1'b0;
      stb     <= '0;
    end else begin
      winCnt      <= winCnt + 1'b1;
      stb.verdict <= windowEnd && primed;
      stb.pass    <= windowEnd && primed && deltaOk;
      if (windowEnd) begin
        lastBin <= curBin;
        primed  <= 1'b1;
      end
    end
  end

  // R7: verdicts are single-cycle pulses, never back to back.
  a_r7_single_verdict: assert property (@(posedge refClk) disable iff (!rstN)
    stb.verdict |=> !stb.verdict);
  // R8: no verdict may appear before a window end has primed the snapshot.
  a_r8_primed_first: assert property (@(posedge refClk) disable iff (!rstN)
    !primed |-> !stb.verdict);
endmodule

// File: rtl/rfm_control.sv
module rfm_control
  import rfm_pkg::*;
#(
  parameter int LOCK_WINDOWS = 2
) (
  input  logic        refClk,
  input  logic        rstN,
  input  rfm_strobe_t stb,
  output logic        inRange,
  output logic        lockData
);
  localparam int GC_W = $clog2(LOCK_WINDOWS + 1);
  logic [GC_W-1:0] goodCnt;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      inRange  <= 1'b0;
      lockData <= 1'b0;
      goodCnt  <= '0;
    end else if (stb.verdict) begin
      inRange <= stb.pass;
      if (stb.pass) begin
        if (goodCnt < GC_W'(LOCK_WINDOWS)) goodCnt <= goodCnt + 1'b1;
        if (goodCnt >= GC_W'(LOCK_WINDOWS - 1)) lockData <= 1'b1;
      end else begin
        goodCnt  <= '0;
        lockData <= 1'b0;
      end
    end
  end

  // R5: tracking data requires the current window to be in range.
  a_r5_lock_implies_range: assert property (@(posedge refClk) disable iff (!rstN)
    lockData |-> inRange);
  // R5: lock rises only when the previous window was already in range.
  a_r5_two_windows: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(lockData) |-> $past(inRange));
  // R6: one failing window clears both outputs.
  a_r6_fail_drops: assert property (@(posedge refClk) disable iff (!rstN)
    (stb.verdict && !stb.pass) |=> (!inRange && !lockData));
  // R7: outputs hold between verdicts.
  a_r7_hold: assert property (@(posedge refClk) disable iff (!rstN)
    !stb.verdict |=> ($stable(inRange) && $stable(lockData)));
endmodule

// File: rtl/rx_freq_monitor.sv
module rx_freq_monitor
  import rfm_pkg::*;
#(
  parameter int WIN_BITS     = 16,
  parameter int TOL_PPM      = 200,
  parameter int SYNC_STAGES  = 2,
  parameter int LOCK_WINDOWS = 2
) (
  input  logic refClk,
  input  logic recClk,
  input  logic rstN,
  input  logic halfRate,
  output logic inRange,
  output logic lockData
);
  rfm_strobe_t stb;

  rfm_datapath #(
    .WIN_BITS(WIN_BITS), .TOL_PPM(TOL_PPM), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .refClk(refClk), .recClk(recClk), .rstN(rstN),
    .halfRate(halfRate), .stb(stb)
  );

  rfm_control #(.LOCK_WINDOWS(LOCK_WINDOWS)) u_ctl (
    .refClk(refClk), .rstN(rstN), .stb(stb),
    .inRange(inRange), .lockData(lockData)
  );
endmodule

// File: tb/sim_rx_freq_monitor.sv
`timescale 1ns/1ps
module sim_rx_freq_monitor;
  localparam int WIN_BITS = 10;      // 1024-cycle windows
  localparam int TOL_PPM  = 20000;   // tolerance 21 (1:1) / 41 (2:1)
  localparam int WIN      = 1 << WIN_BITS;
  localparam int NV       = 10;
  // {halfRate, recovered half-period in ps, expected in range}
  localparam int VEC [NV][3] = '{
    '{0, 2500, 1},   // R2 exact 1:1
    '{0, 2463, 1},   // R4 +15 counts, inside
    '{0, 2538, 1},   // R4 -15 counts, inside
    '{0, 2427, 0},   // R4 +31 counts, outside
    '{0, 2577, 0},   // R4 -31 counts, outside
    '{1, 1250, 1},   // R3 exact 2:1
    '{1, 1231, 1},   // R3/R4 +32 counts, inside
    '{1, 1289, 0},   // R3/R4 -62 counts, outside
    '{1, 2500, 0},   // R3 char-rate clock with half-rate reference
    '{0, 1250, 0}    // R3 double clock with char-rate reference
  };

  logic refClk = 0, recClk = 0, rstN = 0, halfRate = 0;
  logic inRange, lockData;
  logic recRun = 1;
  real  recHalfNs = 2.5;
  int   checks = 0, errors = 0;
  logic done = 0;

  rx_freq_monitor #(.WIN_BITS(WIN_BITS), .TOL_PPM(TOL_PPM)) u0 (
    .refClk(refClk), .recClk(recClk), .rstN(rstN), .halfRate(halfRate),
    .inRange(inRange), .lockData(lockData)
  );

  always #2.5 refClk = ~refClk;
  initial forever begin
    #(recHalfNs);
    if (recRun) recClk = ~recClk;
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic refCycles(input int n);
    repeat (n) @(posedge refClk);
    @(negedge refClk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #750us;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int t;
    // R1: reset state
    refCycles(5);
    check("R1 inRange in reset", inRange, 1'b0);
    check("R1 lockData in reset", lockData, 1'b0);
    rstN = 1;
    refCycles(10);
    check("R1 inRange after release", inRange, 1'b0);
    check("R1 lockData after release", lockData, 1'b0);

    // R8: first verdict only after the second window
    t = 10;
    while (!inRange && t < 3 * WIN) begin refCycles(1); t++; end
    checks++;
    if (t < 2 * WIN - 4 || t > 2 * WIN + 8) begin
      errors++;
      $display("FAIL R8 first verdict cycle: actual %0d expected %0d", t, 2 * WIN);
    end
    // R5: one good window is not enough to lock
    check("R5 no lock after one good window", lockData, 1'b0);
    refCycles(WIN - 20);
    check("R5/R7 still no lock within window", lockData, 1'b0);
    refCycles(30);
    check("R5 lock after two good windows", lockData, 1'b1);

    // R6: locked link steps out of tolerance
    recHalfNs = 2.427;
    t = 0;
    while (inRange && t < 3 * WIN) begin refCycles(1); t++; end
    check("R6 inRange dropped", inRange, 1'b0);
    check("R6 lockData dropped with inRange", lockData, 1'b0);

    // R2/R3/R4: table walk
    for (int i = 0; i < NV; i++) begin
      halfRate  = VEC[i][0][0];
      recHalfNs = VEC[i][1] / 1000.0;
      refCycles(3 * WIN + 100);
      check($sformatf("R2/R3/R4 vec%0d inRange", i), inRange, VEC[i][2][0]);
      check($sformatf("R5 vec%0d lockData", i), lockData, VEC[i][2][0]);
    end

    // R9: stopped recovered clock after a good lock
    halfRate = 0; recHalfNs = 2.5;
    refCycles(3 * WIN + 100);
    check("R9 precondition locked", lockData, 1'b1);
    recRun = 0;
    refCycles(2 * WIN + 100);
    check("R9 stopped clock inRange", inRange, 1'b0);
    check("R9 stopped clock lockData", lockData, 1'b0);

    // R1: reset mid-lock returns to the reset state
    recRun = 1;
    refCycles(3 * WIN + 100);
    rstN = 0;
    refCycles(3);
    check("R1 re-reset inRange", inRange, 1'b0);
    check("R1 re-reset lockData", lockData, 1'b0);

    done = 1;
    summary();
  end
endmodule